// File: doc/BRIEF.md
# Process-Tagged Translation Cache

This block is a small fully associative cache of page table entries. A requester presents a virtual address. In the same cycle the block reports whether a valid entry exists for that page number under the current process id. On a hit it returns the physical address, built from the cached frame number and the unchanged in-page offset, along with the dirty, referenced and writable bits. On a miss it raises a miss flag. The requester then fetches the page table entry on its own and installs it through the refill port.

Every entry carries a process id tag, so mappings from several processes can live side by side. For a context switch there are two options. Software can empty the whole cache in one cycle, or it can drop the entries of a single process id and keep the others. The hardware chooses the slot that a refill writes, and software has no say in it. A refill of a mapping that is already present rewrites its slot. Otherwise the refill takes the lowest free slot. When no slot is free, a round-robin pointer chooses the victim.

Top module: `xlate_cache`

## Requirements
- R1: After reset every slot is empty, every lookup misses, and the round-robin pointer is at slot 0.
- R2: When `lk_valid` is high and a valid slot matches both the page number `lk_vaddr[VPN_W+OFS_W-1:OFS_W]` and `cur_asid`, `lk_hit` rises in the same cycle. `lk_paddr` then equals `{frame, lk_vaddr[OFS_W-1:0]}`, and `lk_dirty`, `lk_ref` and `lk_wr` show the slot's bits.
- R3: A lookup with no matching slot drives `lk_miss` high and `lk_hit` low, and `lk_paddr` and the flags are zero. With `lk_valid` low, both `lk_hit` and `lk_miss` are low.
- R4: A slot whose process tag differs from `cur_asid` never produces a hit, even when its page number matches.
- R5: A refill whose page number and process id are already present rewrites that slot, so no duplicate is created. At most one slot matches any lookup.
- R6: Any other refill writes the lowest-numbered empty slot, if one exists.
- R7: When every slot is full, a new refill writes the slot that the round-robin pointer selects. The pointer advances by one on every accepted refill and wraps from ENTRIES-1 to 0.
- R8: `flush_all` empties every slot and resets the pointer to 0 at the next edge. A refill in the same cycle is discarded.
- R9: `flush_asid_en` empties, at the next edge, every slot whose tag equals `flush_asid` and leaves the other slots unchanged. A refill in the same cycle is still installed and is valid afterwards.
- R10: A lookup in the same cycle as a refill sees the contents from before the refill. The new entry hits from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | ASID_W | Process id of the running process |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFS_W | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation found |
| lk_paddr | output | PFN_W+OFS_W | Translated physical address |
| lk_dirty | output | 1 | Dirty bit of the hit slot |
| lk_ref | output | 1 | Referenced bit of the hit slot |
| lk_wr | output | 1 | Writable bit of the hit slot |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Process tag to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_dirty | input | 1 | Dirty bit to install |
| fill_ref | input | 1 | Referenced bit to install |
| fill_wr | input | 1 | Writable bit to install |
| flush_all | input | 1 | Empty every slot |
| flush_asid_en | input | 1 | Empty the slots of one process |
| flush_asid | input | ASID_W | Process id to drop |

## Verification
The hardest case to reach is a victim choice in which the lowest free slot and the round-robin pointer point to different slots. The cache must be full, with the pointer back at slot 0, and must then have exactly one hole in the middle. The stimulus fills all 64 slots after a full flush, tagging slot 10 with a process id of its own, and then drops that process id. The next refill must land in slot 10, which leaves slot 0 intact. The refill after that must evict slot 1, so the pointer must have advanced on the refill that went into the hole. Both outcomes are read back through ordinary lookups.

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 11,
  parameter int OFS_W   = 13,
  parameter int PFN_W   = 19,
  parameter int ASID_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ASID_W-1:0]       cur_asid,
  input  logic                    lk_valid,
  input  logic [VPN_W+OFS_W-1:0]  lk_vaddr,
  output logic                    lk_hit,
  output logic                    lk_miss,
  output logic [PFN_W+OFS_W-1:0]  lk_paddr,
  output logic                    lk_dirty,
  output logic                    lk_ref,
  output logic                    lk_wr,
  input  logic                    fill_en,
  input  logic [VPN_W-1:0]        fill_vpn,
  input  logic [ASID_W-1:0]       fill_asid,
  input  logic [PFN_W-1:0]        fill_pfn,
  input  logic                    fill_dirty,
  input  logic                    fill_ref,
  input  logic                    fill_wr,
  input  logic                    flush_all,
  input  logic                    flush_asid_en,
  input  logic [ASID_W-1:0]       flush_asid
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];
  logic [ENTRIES-1:0] e_dirty, e_ref, e_wr;

  logic [IDX_W-1:0]   rr;
  logic [ENTRIES-1:0] lk_match, fill_match, drop_match;
  wire  [VPN_W-1:0]   lk_vpn = lk_vaddr[VPN_W+OFS_W-1:OFS_W];

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lk_match[g]   = valid[g] && e_vpn[g] == lk_vpn && e_asid[g] == cur_asid;
      assign fill_match[g] = valid[g] && e_vpn[g] == fill_vpn && e_asid[g] == fill_asid;
      assign drop_match[g] = e_asid[g] == flush_asid;
    end
  endgenerate

  logic [PFN_W-1:0] sel_pfn;
  logic             sel_d, sel_r, sel_w;
  always_comb begin
    sel_pfn = '0;
    sel_d = 1'b0;
    sel_r = 1'b0;
    sel_w = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        sel_pfn = sel_pfn | e_pfn[i];
        sel_d   = sel_d | e_dirty[i];
        sel_r   = sel_r | e_ref[i];
        sel_w   = sel_w | e_wr[i];
      end
    end
  end

  wire any_match = |lk_match;
  assign lk_hit   = lk_valid && any_match;
  assign lk_miss  = lk_valid && !any_match;
  assign lk_paddr = lk_hit ? {sel_pfn, lk_vaddr[OFS_W-1:0]} : '0;
  assign lk_dirty = lk_hit && sel_d;
  assign lk_ref   = lk_hit && sel_r;
  assign lk_wr    = lk_hit && sel_w;

  logic             dup_any, free_any;
  logic [IDX_W-1:0] dup_idx, free_idx, victim;
  always_comb begin
    dup_any  = 1'b0;
    free_any = 1'b0;
    dup_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_match[i]) begin
        dup_any = 1'b1;
        dup_idx = IDX_W'(i);
      end
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
  assign victim = dup_any ? dup_idx : (free_any ? free_idx : rr);

  wire do_fill = fill_en && !flush_all;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_all) begin
      valid <= '0;
      rr    <= '0;
    end else begin
      if (flush_asid_en) valid <= valid & ~drop_match;
      if (fill_en) begin
        valid[victim] <= 1'b1;
        rr <= (rr == LAST) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      e_vpn[victim]   <= fill_vpn;
      e_asid[victim]  <= fill_asid;
      e_pfn[victim]   <= fill_pfn;
      e_dirty[victim] <= fill_dirty;
      e_ref[victim]   <= fill_ref;
      e_wr[victim]    <= fill_wr;
    end
  end

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss)); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_paddr == '0 && !lk_dirty && !lk_ref && !lk_wr)); // R3
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid == '0)); // R8
  AST_DROP_ASID: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_asid_en && !fill_en && !flush_all) |=> ((valid & $past(drop_match)) == '0)); // R9
  AST_GROW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_all |=> ($countones(valid) <= $past($countones(valid)) + 1)); // R6
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_all) |=> (valid != '0)); // R7
endmodule

// File: tb/xlate_cache_tb.sv
module xlate_cache_tb;
  localparam int ENTRIES = 64, VPN_W = 11, OFS_W = 13, PFN_W = 19, ASID_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ASID_W-1:0] cur_asid = '0;
  logic lk_valid = 1'b0;
  logic [VPN_W+OFS_W-1:0] lk_vaddr = '0;
  logic lk_hit, lk_miss, lk_dirty, lk_ref, lk_wr;
  logic [PFN_W+OFS_W-1:0] lk_paddr;
  logic fill_en = 1'b0, fill_dirty = 1'b0, fill_ref = 1'b0, fill_wr = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [ASID_W-1:0] fill_asid = '0, flush_asid = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic flush_all = 1'b0, flush_asid_en = 1'b0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  xlate_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .OFS_W(OFS_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_dirty(lk_dirty),
    .lk_ref(lk_ref), .lk_wr(lk_wr), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_pfn(fill_pfn), .fill_dirty(fill_dirty), .fill_ref(fill_ref),
    .fill_wr(fill_wr), .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input logic [PFN_W-1:0] p,
                      input logic d, input logic r, input logic w);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p;
    fill_dirty = d; fill_ref = r; fill_wr = w;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic look(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] v, input logic [OFS_W-1:0] o);
    @(negedge clk);
    cur_asid = a; lk_valid = 1'b1; lk_vaddr = {v, o};
    #1;
  endtask

  task automatic expect_hit(string req, logic [ASID_W-1:0] a, logic [VPN_W-1:0] v, logic [PFN_W-1:0] p);
    look(a, v, 13'h0155);
    check(req, {lk_hit, lk_miss}, 2'b10);
    check(req, lk_paddr, {p, 13'h0155});
  endtask

  task automatic expect_miss(string req, logic [ASID_W-1:0] a, logic [VPN_W-1:0] v);
    look(a, v, 13'h0155);
    check(req, {lk_hit, lk_miss, lk_dirty, lk_ref, lk_wr}, 5'b01000);
    check(req, lk_paddr, '0);
  endtask

  task automatic do_flush_all();
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); lk_valid = 1'b0; #1;
    check("R3 idle", {lk_hit, lk_miss}, 2'b00);
    expect_miss("R1 reset", 8'd0, 11'd0);
    expect_miss("R1 reset", 8'd3, 11'd5);
  endtask

  task automatic t_basic();
    fill(11'd5, 8'd3, 19'h01234, 1'b1, 1'b0, 1'b1);
    look(8'd3, 11'd5, 13'h0abc);
    check("R2 hit", lk_hit, 1'b1);
    check("R2 paddr", lk_paddr, {19'h01234, 13'h0abc});
    check("R2 flags", {lk_dirty, lk_ref, lk_wr}, 3'b101);
    expect_miss("R3 other page", 8'd3, 11'd6);
    expect_miss("R4 other asid", 8'd4, 11'd5);
  endtask

  task automatic t_overwrite();
    fill(11'd5, 8'd3, 19'h00777, 1'b0, 1'b1, 1'b0);
    look(8'd3, 11'd5, 13'h0001);
    check("R5 rewrite", lk_paddr, {19'h00777, 13'h0001});
    check("R5 flags", {lk_hit, lk_dirty, lk_ref, lk_wr}, 4'b1010);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cur_asid = 8'd3; lk_valid = 1'b1; lk_vaddr = {11'd9, 13'h0002};
    fill_en = 1'b1; fill_vpn = 11'd9; fill_asid = 8'd3; fill_pfn = 19'h00abc;
    fill_dirty = 1'b0; fill_ref = 1'b0; fill_wr = 1'b0;
    #1;
    check("R10 old view", {lk_hit, lk_miss}, 2'b01);
    @(negedge clk); fill_en = 1'b0; #1;
    check("R10 new view", {lk_hit, lk_miss}, 2'b10);
  endtask

  task automatic t_flush_all();
    @(negedge clk);
    flush_all = 1'b1;
    fill_en = 1'b1; fill_vpn = 11'd20; fill_asid = 8'd3; fill_pfn = 19'h1;
    @(negedge clk); flush_all = 1'b0; fill_en = 1'b0;
    expect_miss("R8 flushed", 8'd3, 11'd5);
    expect_miss("R8 flushed", 8'd3, 11'd9);
    expect_miss("R8 fill dropped", 8'd3, 11'd20);
  endtask

  task automatic t_flush_asid();
    fill(11'd1, 8'd1, 19'h00011, 1'b0, 1'b0, 1'b0);
    fill(11'd2, 8'd2, 19'h00022, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    flush_asid_en = 1'b1; flush_asid = 8'd1;
    fill_en = 1'b1; fill_vpn = 11'd3; fill_asid = 8'd1; fill_pfn = 19'h00033;
    @(negedge clk); flush_asid_en = 1'b0; fill_en = 1'b0;
    expect_miss("R9 dropped", 8'd1, 11'd1);
    expect_hit("R9 kept", 8'd2, 11'd2, 19'h00022);
    expect_hit("R9 fill survives", 8'd1, 11'd3, 19'h00033);
  endtask

  task automatic t_victim();
    do_flush_all();
    for (int i = 0; i < ENTRIES; i++)
      fill(11'(100 + i), (i == 10) ? 8'd8 : 8'd7, 19'(16'h100 + i), 1'b0, 1'b0, 1'b0);
    expect_hit("R6 full", 8'd7, 11'd163, 19'(16'h100 + 63));
    @(negedge clk); flush_asid_en = 1'b1; flush_asid = 8'd8;
    @(negedge clk); flush_asid_en = 1'b0;
    fill(11'd200, 8'd7, 19'h00200, 1'b0, 1'b0, 1'b0);
    expect_hit("R6 hole used", 8'd7, 11'd100, 19'h00100);
    expect_hit("R6 hole used", 8'd7, 11'd200, 19'h00200);
    fill(11'd201, 8'd7, 19'h00201, 1'b0, 1'b0, 1'b0);
    expect_miss("R7 rr evict", 8'd7, 11'd101);
    expect_hit("R7 slot0 kept", 8'd7, 11'd100, 19'h00100);
    expect_hit("R7 new", 8'd7, 11'd201, 19'h00201);
    fill(11'd202, 8'd7, 19'h00202, 1'b0, 1'b0, 1'b0);
    expect_miss("R7 rr next", 8'd7, 11'd102);
    expect_hit("R7 neighbour", 8'd7, 11'd103, 19'h00103);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_overwrite();
    t_same_cycle();
    t_flush_all();
    t_flush_asid();
    t_victim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule